// File: doc/BRIEF.md
# PIO Transfer Byte Counter

This block keeps the number of bytes still to move in a host-directed transfer that runs over an IDE port as programmed-I/O data cycles. Software writes a byte count through a simple write strobe and picks one of two modes at that write. In the full-width mode, which feeds a virtual DMA transfer, every bit of the written word is kept. In the read-ahead mode only the low half is kept.

Once the bus-master enable is high, a start pulse arms the counter. While it is armed and bytes remain, the block requests data cycles. Each reported 16-bit cycle takes two bytes off the count. When the count reaches zero, a completion flag rises. The flag holds until the bus-master enable is dropped.

Top module: `pio_xfer_counter`

## Requirements
- R1: After synchronous reset, `remain` is 0 and `xfer_done`, `cyc_req` and `cfg_err` are all low.
- R2: A write with `cfg_mode` = 0 (full-width mode) loads all 32 bits of `cfg_wdata` into `remain`, except bit 0.
- R3: A write with `cfg_mode` = 1 (read-ahead mode) loads only `cfg_wdata[15:0]`. Bits 31:16 of `remain` become 0 whatever was written there.
- R4: A read-ahead write with any of `cfg_wdata[31:16]` nonzero sets `cfg_err`. The flag stays set until reset, and later valid writes do not clear it.
- R5: Bit 0 of a written count is dropped, so an odd count is rounded down to the even value below it.
- R6: A `start` pulse while `bm_en` is high and `remain` is nonzero raises `cyc_req` on the next clock. `cyc_req` stays high while bytes remain and `bm_en` stays high.
- R7: Each `cyc_done` pulse while `cyc_req` is high lowers `remain` by 2 on that clock. A `cyc_done` pulse while `cyc_req` is low changes nothing.
- R8: On the clock where the last data cycle brings `remain` to 0, `xfer_done` rises and `cyc_req` falls.
- R9: `xfer_done` stays high while `bm_en` stays high. It clears on the first clock that samples `bm_en` low.
- R10: A `start` pulse with `bm_en` high and `remain` = 0 sets `xfer_done` on the next clock and issues no data-cycle request.
- R11: A `start` pulse while `bm_en` is low is ignored.
- R12: A count write while `cyc_req` is high is ignored. Dropping `bm_en` during a transfer stops requests, keeps `remain` unchanged and leaves `xfer_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Count write strobe |
| cfg_mode | input | 1 | Mode for this write: 0 full-width, 1 read-ahead |
| cfg_wdata | input | 32 | Written byte count |
| bm_en | input | 1 | Bus-master enable |
| start | input | 1 | One-cycle transfer start pulse |
| cyc_done | input | 1 | One-cycle pulse: a 16-bit data cycle finished |
| cyc_req | output | 1 | Request for another data cycle |
| remain | output | 32 | Bytes still to transfer |
| xfer_done | output | 1 | Transfer completion flag |
| cfg_err | output | 1 | Sticky flag: bad upper bits in a read-ahead write |

## Verification
The assertions take `start` and `cyc_done` to be single-cycle pulses. They also assume the count changes only through the write strobe or a reported data cycle, so `remain` is always even and a request always has bytes behind it. The directed tasks drive every pulse for exactly one clock, at the falling edge. They raise `cyc_done` only where the test intends a cycle to count, or deliberately while no request is pending to show that it is ignored. They write counts during a transfer only to show that such writes are dropped.

// File: rtl/pio_cnt_pkg.sv
package pio_cnt_pkg;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_RA   = 1'b1
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic running;
        logic done;
    } seq_flags_t;

    function automatic logic is_armed(input logic start, input logic bm_en);
        return start && bm_en;
    endfunction

endpackage

// File: rtl/pio_cnt_loader.sv
module pio_cnt_loader
    import pio_cnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int RA_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] ld_val,
    output logic             cfg_err
);
    localparam int UP_W = CNT_W - RA_W;

    logic upper_bad;

    always_comb begin
        ld_val    = wdata & ~CNT_W'(1);
        upper_bad = 1'b0;
        if (mode == MODE_RA) begin
            ld_val[CNT_W-1:RA_W] = '0;
            upper_bad = (wdata[CNT_W-1:RA_W] != UP_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if (ld_en && upper_bad)
            cfg_err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err); // R4

endmodule

// File: rtl/pio_cnt_down.sv
module pio_cnt_down #(
    parameter int CNT_W = 32,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_last
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (ld_en)
            count <= ld_val;
        else if (dec_en)
            count <= count - STEP_V;
    end

    assign is_zero = (count == '0);
    assign is_last = (count == STEP_V);

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !ld_en) |=> (count == $past(count) - STEP_V)); // R7

    AST_EVEN_COUNT: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> !count[0]); // R5

endmodule

// File: rtl/pio_cnt_seq.sv
module pio_cnt_seq
    import pio_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bm_en,
    input  logic       cyc_done,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output seq_flags_t flags
);
    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: if (is_armed(start, bm_en))
                          state_nx = cnt_zero ? SEQ_DONE : SEQ_RUN;
            SEQ_RUN:  if (!bm_en)
                          state_nx = SEQ_IDLE;
                      else if (cyc_done && cnt_last)
                          state_nx = SEQ_DONE;
            SEQ_DONE: if (!bm_en)
                          state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_nx;
    end

    assign flags.running = (state == SEQ_RUN);
    assign flags.done    = (state == SEQ_DONE);

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flags.done && bm_en) |=> flags.done); // R9

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (rst)
        !bm_en |=> !flags.done); // R9

    AST_ZERO_START: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && start && bm_en && cnt_zero) |=> flags.done); // R10

    AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && !bm_en) |=> !flags.running); // R11

endmodule

// File: rtl/pio_xfer_counter.sv
module pio_xfer_counter
    import pio_cnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int RA_W  = 16,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_mode,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             bm_en,
    input  logic             start,
    input  logic             cyc_done,
    output logic             cyc_req,
    output logic [CNT_W-1:0] remain,
    output logic             xfer_done,
    output logic             cfg_err
);
    seq_flags_t       flags;
    logic             ld_en;
    logic             dec_en;
    logic             cnt_zero;
    logic             cnt_last;
    logic [CNT_W-1:0] ld_val;
    cnt_mode_e        mode;

    assign mode   = cnt_mode_e'(cfg_mode);
    assign ld_en  = cfg_wr && !flags.running;
    assign dec_en = flags.running && bm_en && cyc_done;

    pio_cnt_loader #(.CNT_W(CNT_W), .RA_W(RA_W)) u_loader (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .mode   (mode),
        .wdata  (cfg_wdata),
        .ld_val (ld_val),
        .cfg_err(cfg_err)
    );

    pio_cnt_down #(.CNT_W(CNT_W), .STEP(STEP)) u_down (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .dec_en (dec_en),
        .count  (remain),
        .is_zero(cnt_zero),
        .is_last(cnt_last)
    );

    pio_cnt_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bm_en   (bm_en),
        .cyc_done(cyc_done),
        .cnt_zero(cnt_zero),
        .cnt_last(cnt_last),
        .flags   (flags)
    );

    assign cyc_req   = flags.running && bm_en;
    assign xfer_done = flags.done;

    AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (rst)
        cyc_req |-> (remain != '0)); // R6

    AST_RA_UPPER: assert property (@(posedge clk) disable iff (rst)
        (ld_en && mode == MODE_RA) |=> (remain[CNT_W-1:RA_W] == '0)); // R3

    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cyc_req && !cyc_done) |=> $stable(remain)); // R12

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !cyc_req); // R8

endmodule

// File: tb/pio_xfer_counter_test.sv
`timescale 1ns/1ps
module pio_xfer_counter_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr, cfg_mode, bm_en, start, cyc_done;
    logic [31:0] cfg_wdata;
    logic        cyc_req, xfer_done, cfg_err;
    logic [31:0] remain;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pio_xfer_counter uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_wdata(cfg_wdata), .bm_en(bm_en), .start(start),
        .cyc_done(cyc_done), .cyc_req(cyc_req), .remain(remain),
        .xfer_done(xfer_done), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cnt(input logic mode, input logic [31:0] val);
        cfg_wr = 1; cfg_mode = mode; cfg_wdata = val;
        step();
        cfg_wr = 0;
    endtask

    task automatic pulse_start();
        start = 1; step(); start = 0;
    endtask

    task automatic pulse_done();
        cyc_done = 1; step(); cyc_done = 0;
    endtask

    task automatic t_reset();
        rst = 1; cfg_wr = 0; cfg_mode = 0; cfg_wdata = 0;
        bm_en = 0; start = 0; cyc_done = 0;
        step(); step();
        rst = 0; step();
        check("R1 remain", remain, 0);
        check("R1 done", xfer_done, 0);
        check("R1 req", cyc_req, 0);
        check("R1 err", cfg_err, 0);
    endtask

    task automatic t_loads();
        write_cnt(0, 32'h0001_2345);
        check("R2 R5 full-width odd", remain, 32'h0001_2344);
        write_cnt(0, 32'hFFFF_FFFE);
        check("R2 full-width top", remain, 32'hFFFF_FFFE);
        write_cnt(1, 32'h0000_0100);
        check("R3 read-ahead", remain, 32'h0000_0100);
        check("R4 no err", cfg_err, 0);
        write_cnt(1, 32'h0000_FFFF);
        check("R5 read-ahead odd", remain, 32'h0000_FFFE);
        write_cnt(1, 32'hABCD_0011);
        check("R3 upper dropped", remain, 32'h0000_0010);
        check("R4 err set", cfg_err, 1);
        write_cnt(0, 32'h0000_0040);
        check("R4 err sticky", cfg_err, 1);
        check("R2 load after err", remain, 32'h0000_0040);
    endtask

    task automatic t_run();
        write_cnt(0, 32'd6);
        bm_en = 1; step();
        pulse_start();
        check("R6 req up", cyc_req, 1);
        check("R6 count", remain, 6);
        pulse_done();
        check("R7 dec", remain, 4);
        step();
        check("R6 req held", cyc_req, 1);
        check("R7 no pulse", remain, 4);
        write_cnt(0, 32'h0000_0100);
        check("R12 load ignored", remain, 4);
        pulse_done();
        check("R7 dec2", remain, 2);
        check("R8 not yet", xfer_done, 0);
        pulse_done();
        check("R8 zero", remain, 0);
        check("R8 done", xfer_done, 1);
        check("R8 req down", cyc_req, 0);
        pulse_done();
        check("R7 ignored", remain, 0);
        step(); step();
        check("R9 hold", xfer_done, 1);
        bm_en = 0; step();
        check("R9 cleared", xfer_done, 0);
    endtask

    task automatic t_zero_start();
        write_cnt(0, 32'd0);
        bm_en = 1; step();
        pulse_start();
        check("R10 done", xfer_done, 1);
        check("R10 no req", cyc_req, 0);
        bm_en = 0; step();
        check("R9 cleared zero", xfer_done, 0);
    endtask

    task automatic t_start_ignored();
        write_cnt(0, 32'd8);
        bm_en = 0;
        pulse_start();
        check("R11 no req", cyc_req, 0);
        check("R11 no done", xfer_done, 0);
        pulse_done();
        check("R11 count kept", remain, 8);
    endtask

    task automatic t_abort();
        bm_en = 1; step();
        pulse_start();
        pulse_done();
        check("R7 abort dec", remain, 6);
        bm_en = 0; step();
        check("R12 abort req", cyc_req, 0);
        check("R12 abort count", remain, 6);
        check("R12 abort done", xfer_done, 0);
    endtask

    initial begin
        t_reset();
        t_loads();
        t_run();
        t_zero_start();
        t_start_ignored();
        t_abort();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule